// File: doc/BRIEF.md
# Link Authentication Control Sequencer

This block steers the three-phase authentication of a protected display link. A start request makes it load the transmitter keys from a key store, retrying and clearing the store between failed loads. It then seeds and captures a random session value, sends that value to the receiver and fetches the receiver's 40-bit key vector. It enables link signalling and the cipher, waits out a minimum window before reading the receiver's first verification value, and waits for the cipher to report a match and then active encryption. When the sink is a repeater, it also waits for the downstream list, checks the topology report and asks for the downstream hash check. Failed attempts are undone and retried a bounded number of times.

Commands leave on one command port, with one command outstanding at a time, and each is answered by a response strobe. The cipher reports its progress as level flags. After success the block holds the link in the protected state and runs a periodic check on every tick. A tick with encryption gone drops the state to "wanted". A failed link integrity check tears the link down and runs the full sequence again. Every timeout is a count of clock cycles set by a parameter.

Top module: `link_auth_seq`

## Requirements
- R1: A key load succeeds only when its response has bit 0 (done) and bit 1 (good) both set. At most KEY_TRIES (5) loads are made, with one clear command between consecutive failed loads and none after the last one. If every load fails, the block pulses fail with code 1 and issues no further commands.
- R2: After a good load, the block issues one key-forward command, then two seed commands whose data are the rnd_i words sampled when each is issued, then one capture command. It then waits for an_ready_i. If an_ready_i is not seen within STAT_TMO cycles, the attempt fails with code 2.
- R3: A receiver key vector (rsp_data_i[39:0]) is accepted only if it has exactly 20 ones. It is read at most RXKEY_TRIES (2) times per attempt; if both reads are bad, the attempt fails with code 3.
- R4: The verification-value read is issued no earlier than R0_WAIT cycles after the session-value send command of the same attempt.
- R5: The verification value is read up to RI_TRIES (3) times per attempt. After each read the block waits up to STAT_TMO cycles for ri_match_i, and fails the attempt with code 4 when all reads go unmatched.
- R6: After a match, enc_active_i must be seen within ENC_TMO cycles, or the attempt fails with code 5.
- R7: With repeater_i high, the block waits up to LIST_TMO cycles for list_ready_i (timeout: code 6) and then reads a list status. The attempt fails with code 7 if status bit 7 (too many devices) or bit 11 (too deep) is set, and with code 8 if the device count in bits 6:0 is zero.
- R8: The downstream hash check passes when its response has rsp_ok_i high. It is tried up to HASH_TRIES (3) times per attempt; if all tries fail, the attempt fails with code 9.
- R9: A failed attempt is followed by a cipher-off command and then a signal-off command. The sequence restarts from the seed step up to AUTH_TRIES (3) attempts in all. Only the last failure pulses fail_o, carrying that attempt's code, and leaves prot_state_o at 0 (off) for a start-initiated run.
- R10: A successful run pulses done_o for one cycle with fail_code_o 0 and prot_state_o 2 (protected). done_o and fail_o are never high together.
- R11: In the protected state, a check_tick_i with enc_active_i low pulses fail_o with code 10, sets prot_state_o to 1 (wanted) and returns to idle. A tick whose link-check response has rsp_ok_i low sets prot_state_o to 1, issues cipher-off and signal-off, and reruns the full sequence from key load.
- R12: After reset, state_o is 0, prot_state_o is 0, and cmd_valid_o, done_o and fail_o are low.
- R13: cmd_valid_o is a one-cycle pulse, and no new command is issued until the previous one has its response. Command codes: 1 key load, 2 key clear, 3 key forward, 4 seed, 5 capture, 6 session send, 7 receiver key read, 8 signal on, 9 cipher start, 10 verification read, 11 list status, 12 hash check, 13 cipher off, 14 signal off, 15 link check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin authentication (accepted when idle) |
| check_tick_i | input | 1 | Periodic check request |
| repeater_i | input | 1 | Sink is a repeater |
| rnd_i | input | 32 | Random word for seeding |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_code_o | output | 4 | Command code |
| cmd_data_o | output | 32 | Command payload (seed word) |
| rsp_valid_i | input | 1 | Response strobe for the outstanding command |
| rsp_ok_i | input | 1 | Pass flag of the response |
| rsp_data_i | input | 40 | Response payload |
| an_ready_i | input | 1 | Session value captured |
| ri_match_i | input | 1 | Verification value matched or encrypting |
| enc_active_i | input | 1 | Encryption running |
| list_ready_i | input | 1 | Downstream list ready |
| done_o | output | 1 | Success pulse |
| fail_o | output | 1 | Failure pulse |
| fail_code_o | output | 4 | Failure reason, 0 after success |
| prot_state_o | output | 2 | 0 off, 1 wanted, 2 protected |
| state_o | output | 5 | Current sequencer state, for test |

## Verification
A wrong retry counter shows up directly as a wrong number of load, read or hash commands on the command port, visible within one attempt. A broken wait timer shows up either as a verification read issued too early after the session send, or as a failure code that appears sooner or later than the configured timeout. A misrouted failure path shows up as a missing cipher-off/signal-off pair or a wrong code on the single fail pulse. The protection state is visible on every cycle, so an error there appears in the cycle after the event that should have changed it.

// File: rtl/link_auth_pkg.sv
package link_auth_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_KEY_LOAD, ST_KEY_CLR, ST_KEY_FWD, ST_SEED, ST_CAPT,
    ST_AN_WAIT, ST_SEND_AN, ST_RXKEY, ST_SIG_ON, ST_AUTH_ENC, ST_R0_WIN,
    ST_RI_READ, ST_RI_CMP, ST_ENC_WAIT, ST_LIST_WAIT, ST_LIST_STAT,
    ST_HASH, ST_CIPH_OFF, ST_SIG_OFF, ST_ON, ST_CHECK
  } seq_state_e;

  typedef enum logic [3:0] {
    CMD_NONE = 4'd0, CMD_KEY_LOAD = 4'd1, CMD_KEY_CLR = 4'd2,
    CMD_KEY_FWD = 4'd3, CMD_SEED = 4'd4, CMD_CAPT = 4'd5,
    CMD_SEND_AN = 4'd6, CMD_RXKEY = 4'd7, CMD_SIG_ON = 4'd8,
    CMD_AUTH_ENC = 4'd9, CMD_RI_READ = 4'd10, CMD_LIST_STAT = 4'd11,
    CMD_HASH = 4'd12, CMD_CIPH_OFF = 4'd13, CMD_SIG_OFF = 4'd14,
    CMD_CHECK = 4'd15
  } cmd_e;

  typedef enum logic [3:0] {
    FC_NONE = 4'd0, FC_KEY = 4'd1, FC_AN_TMO = 4'd2, FC_RXKEY = 4'd3,
    FC_RI = 4'd4, FC_ENC_TMO = 4'd5, FC_LIST_TMO = 4'd6, FC_TOPO = 4'd7,
    FC_NODEV = 4'd8, FC_HASH = 4'd9, FC_LOST = 4'd10
  } fail_e;

  typedef enum logic [1:0] {
    PROT_OFF = 2'd0, PROT_WANT = 2'd1, PROT_ON = 2'd2
  } prot_e;

  // Command that a state issues; CMD_NONE for pure wait states.
  function automatic cmd_e cmd_of(seq_state_e s);
    case (s)
      ST_KEY_LOAD:  return CMD_KEY_LOAD;
      ST_KEY_CLR:   return CMD_KEY_CLR;
      ST_KEY_FWD:   return CMD_KEY_FWD;
      ST_SEED:      return CMD_SEED;
      ST_CAPT:      return CMD_CAPT;
      ST_SEND_AN:   return CMD_SEND_AN;
      ST_RXKEY:     return CMD_RXKEY;
      ST_SIG_ON:    return CMD_SIG_ON;
      ST_AUTH_ENC:  return CMD_AUTH_ENC;
      ST_RI_READ:   return CMD_RI_READ;
      ST_LIST_STAT: return CMD_LIST_STAT;
      ST_HASH:      return CMD_HASH;
      ST_CIPH_OFF:  return CMD_CIPH_OFF;
      ST_SIG_OFF:   return CMD_SIG_OFF;
      ST_CHECK:     return CMD_CHECK;
      default:      return CMD_NONE;
    endcase
  endfunction

  // Population count of a 40-bit key vector.
  function automatic int unsigned ones40(logic [39:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 40; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic topo_exceeded(logic [39:0] s);
    return s[7] | s[11];
  endfunction

  function automatic logic [6:0] dev_count(logic [39:0] s);
    return s[6:0];
  endfunction

endpackage

// File: rtl/lauth_timer.sv
module lauth_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (restart)       cnt_q <= '0;
    else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q >= limit);
endmodule

// File: rtl/lauth_key_check.sv
module lauth_key_check
  import link_auth_pkg::*;
#(
  parameter int KEY_BITS  = 40,
  parameter int WANT_ONES = 20
) (
  input  logic [KEY_BITS-1:0] key,
  output logic                ok
);
  assign ok = (ones40(40'(key)) == WANT_ONES);
endmodule

// File: rtl/link_auth_seq.sv
module link_auth_seq
  import link_auth_pkg::*;
#(
  parameter int KEY_TRIES   = 5,
  parameter int RXKEY_TRIES = 2,
  parameter int RI_TRIES    = 3,
  parameter int HASH_TRIES  = 3,
  parameter int AUTH_TRIES  = 3,
  parameter int STAT_TMO    = 50_000,
  parameter int R0_WAIT     = 15_000_000,
  parameter int ENC_TMO     = 2_500_000,
  parameter int LIST_TMO    = 250_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        check_tick_i,
  input  logic        repeater_i,
  input  logic [31:0] rnd_i,
  output logic        cmd_valid_o,
  output logic [3:0]  cmd_code_o,
  output logic [31:0] cmd_data_o,
  input  logic        rsp_valid_i,
  input  logic        rsp_ok_i,
  input  logic [39:0] rsp_data_i,
  input  logic        an_ready_i,
  input  logic        ri_match_i,
  input  logic        enc_active_i,
  input  logic        list_ready_i,
  output logic        done_o,
  output logic        fail_o,
  output logic [3:0]  fail_code_o,
  output logic [1:0]  prot_state_o,
  output logic [4:0]  state_o
);
  localparam int M1      = (STAT_TMO > ENC_TMO) ? STAT_TMO : ENC_TMO;
  localparam int M2      = (LIST_TMO > R0_WAIT) ? LIST_TMO : R0_WAIT;
  localparam int TMO_MAX = (M1 > M2) ? M1 : M2;
  localparam int TW      = $clog2(TMO_MAX + 1) + 1;
  localparam int KTW     = $clog2(KEY_TRIES + 1);
  localparam int RXW     = $clog2(RXKEY_TRIES + 1);
  localparam int RIW     = $clog2(RI_TRIES + 1);
  localparam int HW      = $clog2(HASH_TRIES + 1);
  localparam int AW      = $clog2(AUTH_TRIES + 1);

  seq_state_e state_q, prev_q;
  logic        pend_q, cmd_valid_q, done_q, fail_q, seed_idx_q;
  logic        relink_q, chk_origin_q;
  cmd_e        cmd_code_q;
  logic [31:0] cmd_data_q;
  fail_e       fail_code_q;
  prot_e       prot_q;
  logic [KTW-1:0] key_try_q;
  logic [RXW-1:0] rx_try_q;
  logic [RIW-1:0] ri_try_q;
  logic [HW-1:0]  hash_try_q;
  logic [AW-1:0]  auth_try_q;

  // Named internal events.
  logic ack, issue, rxkey_good, key_good, step_restart, step_hit;
  logic win_restart, win_hit;
  logic [TW-1:0] step_limit;

  assign ack          = pend_q && rsp_valid_i;
  assign issue        = (cmd_of(state_q) != CMD_NONE) && !pend_q;
  assign key_good     = rsp_data_i[0] && rsp_data_i[1];
  assign step_restart = (state_q != prev_q);
  assign win_restart  = ack && (state_q == ST_SEND_AN);

  always_comb begin
    case (state_q)
      ST_ENC_WAIT:  step_limit = TW'(ENC_TMO);
      ST_LIST_WAIT: step_limit = TW'(LIST_TMO);
      default:      step_limit = TW'(STAT_TMO);
    endcase
  end

  lauth_key_check u_kchk (.key(rsp_data_i), .ok(rxkey_good));

  lauth_timer #(.W(TW)) u_step (
    .clk(clk), .rst_n(rst_n), .restart(step_restart),
    .limit(step_limit), .hit(step_hit));

  lauth_timer #(.W(TW)) u_win (
    .clk(clk), .rst_n(rst_n), .restart(win_restart),
    .limit(TW'(R0_WAIT)), .hit(win_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;   prev_q <= ST_IDLE;
      pend_q <= 1'b0;       cmd_valid_q <= 1'b0;
      cmd_code_q <= CMD_NONE; cmd_data_q <= '0;
      done_q <= 1'b0;       fail_q <= 1'b0;
      fail_code_q <= FC_NONE; prot_q <= PROT_OFF;
      seed_idx_q <= 1'b0;   relink_q <= 1'b0; chk_origin_q <= 1'b0;
      key_try_q <= '0; rx_try_q <= '0; ri_try_q <= '0;
      hash_try_q <= '0; auth_try_q <= '0;
    end else begin
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
      cmd_valid_q <= 1'b0;
      prev_q      <= state_q;
      if (issue) begin
        cmd_valid_q <= 1'b1;
        cmd_code_q  <= cmd_of(state_q);
        cmd_data_q  <= (state_q == ST_SEED) ? rnd_i : 32'd0;
        pend_q      <= 1'b1;
      end
      if (ack) pend_q <= 1'b0;

      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_KEY_LOAD; key_try_q <= '0; auth_try_q <= '0;
          prot_q <= PROT_WANT; chk_origin_q <= 1'b0; fail_code_q <= FC_NONE;
        end
        ST_KEY_LOAD: if (ack) begin
          if (key_good) state_q <= ST_KEY_FWD;
          else if (key_try_q == KTW'(KEY_TRIES - 1)) begin
            fail_q <= 1'b1; fail_code_q <= FC_KEY; state_q <= ST_IDLE;
            prot_q <= chk_origin_q ? PROT_WANT : PROT_OFF;
          end else begin
            key_try_q <= key_try_q + 1'b1; state_q <= ST_KEY_CLR;
          end
        end
        ST_KEY_CLR: if (ack) state_q <= ST_KEY_LOAD;
        ST_KEY_FWD: if (ack) begin state_q <= ST_SEED; seed_idx_q <= 1'b0; end
        ST_SEED: if (ack) begin
          if (seed_idx_q) state_q <= ST_CAPT;
          else            seed_idx_q <= 1'b1;
        end
        ST_CAPT: if (ack) state_q <= ST_AN_WAIT;
        ST_AN_WAIT: begin
          if (an_ready_i)    state_q <= ST_SEND_AN;
          else if (step_hit) begin fail_code_q <= FC_AN_TMO; state_q <= ST_CIPH_OFF; end
        end
        ST_SEND_AN: if (ack) begin state_q <= ST_RXKEY; rx_try_q <= '0; end
        ST_RXKEY: if (ack) begin
          if (rxkey_good) state_q <= ST_SIG_ON;
          else if (rx_try_q == RXW'(RXKEY_TRIES - 1)) begin
            fail_code_q <= FC_RXKEY; state_q <= ST_CIPH_OFF;
          end else rx_try_q <= rx_try_q + 1'b1;
        end
        ST_SIG_ON:   if (ack) state_q <= ST_AUTH_ENC;
        ST_AUTH_ENC: if (ack) state_q <= ST_R0_WIN;
        ST_R0_WIN: if (win_hit) begin state_q <= ST_RI_READ; ri_try_q <= '0; end
        ST_RI_READ: if (ack) state_q <= ST_RI_CMP;
        ST_RI_CMP: begin
          if (ri_match_i) state_q <= ST_ENC_WAIT;
          else if (step_hit) begin
            if (ri_try_q == RIW'(RI_TRIES - 1)) begin
              fail_code_q <= FC_RI; state_q <= ST_CIPH_OFF;
            end else begin
              ri_try_q <= ri_try_q + 1'b1; state_q <= ST_RI_READ;
            end
          end
        end
        ST_ENC_WAIT: begin
          if (enc_active_i) begin
            if (repeater_i) state_q <= ST_LIST_WAIT;
            else begin
              done_q <= 1'b1; fail_code_q <= FC_NONE; prot_q <= PROT_ON; state_q <= ST_ON;
            end
          end else if (step_hit) begin fail_code_q <= FC_ENC_TMO; state_q <= ST_CIPH_OFF; end
        end
        ST_LIST_WAIT: begin
          if (list_ready_i) state_q <= ST_LIST_STAT;
          else if (step_hit) begin fail_code_q <= FC_LIST_TMO; state_q <= ST_CIPH_OFF; end
        end
        ST_LIST_STAT: if (ack) begin
          if (topo_exceeded(rsp_data_i)) begin
            fail_code_q <= FC_TOPO; state_q <= ST_CIPH_OFF;
          end else if (dev_count(rsp_data_i) == 7'd0) begin
            fail_code_q <= FC_NODEV; state_q <= ST_CIPH_OFF;
          end else begin
            hash_try_q <= '0; state_q <= ST_HASH;
          end
        end
        ST_HASH: if (ack) begin
          if (rsp_ok_i) begin
            done_q <= 1'b1; fail_code_q <= FC_NONE; prot_q <= PROT_ON; state_q <= ST_ON;
          end else if (hash_try_q == HW'(HASH_TRIES - 1)) begin
            fail_code_q <= FC_HASH; state_q <= ST_CIPH_OFF;
          end else hash_try_q <= hash_try_q + 1'b1;
        end
        ST_CIPH_OFF: if (ack) state_q <= ST_SIG_OFF;
        ST_SIG_OFF: if (ack) begin
          if (relink_q) begin
            relink_q <= 1'b0; key_try_q <= '0; auth_try_q <= '0;
            state_q <= ST_KEY_LOAD;
          end else if (auth_try_q == AW'(AUTH_TRIES - 1)) begin
            fail_q <= 1'b1; state_q <= ST_IDLE;
            prot_q <= chk_origin_q ? PROT_WANT : PROT_OFF;
          end else begin
            auth_try_q <= auth_try_q + 1'b1; state_q <= ST_SEED; seed_idx_q <= 1'b0;
          end
        end
        ST_ON: if (check_tick_i) begin
          if (!enc_active_i) begin
            fail_q <= 1'b1; fail_code_q <= FC_LOST; prot_q <= PROT_WANT;
            state_q <= ST_IDLE;
          end else state_q <= ST_CHECK;
        end
        ST_CHECK: if (ack) begin
          if (rsp_ok_i) state_q <= ST_ON;
          else begin
            relink_q <= 1'b1; chk_origin_q <= 1'b1; prot_q <= PROT_WANT;
            state_q <= ST_CIPH_OFF;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o  = cmd_valid_q;
  assign cmd_code_o   = cmd_code_q;
  assign cmd_data_o   = cmd_data_q;
  assign done_o       = done_q;
  assign fail_o       = fail_q;
  assign fail_code_o  = fail_code_q;
  assign prot_state_o = prot_q;
  assign state_o      = state_q;
endmodule

// File: rtl/lauth_seq_chk.sv
module lauth_seq_chk #(
  parameter int KEY_TRIES = 5,
  parameter int KTW       = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid_o,
  input logic [3:0]     cmd_code_o,
  input logic           done_o,
  input logic           fail_o,
  input logic [3:0]     fail_code_o,
  input logic [1:0]     prot_state_o,
  input logic [4:0]     state_o,
  input logic           win_hit,
  input logic [KTW-1:0] key_try
);
  // R13
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  // R10
  done_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> prot_state_o == 2'd2);
  // R10
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));
  // R4
  ri_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_code_o == 4'd10) |-> win_hit);
  // R1
  key_tries_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(key_try) < KEY_TRIES);
  // R9
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> fail_code_o != 4'd0);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 5'd0) |-> !cmd_valid_o);
endmodule

bind link_auth_seq lauth_seq_chk #(.KEY_TRIES(KEY_TRIES), .KTW(KTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o),
  .done_o(done_o), .fail_o(fail_o), .fail_code_o(fail_code_o),
  .prot_state_o(prot_state_o), .state_o(state_o), .win_hit(win_hit),
  .key_try(key_try_q));

// File: tb/link_auth_seq_bench.sv
module link_auth_seq_bench;
  localparam int STAT = 20, R0W = 100, ENCT = 30, LISTT = 60;
  localparam logic [39:0] GOOD_KEY = 40'hF0F0F0F0F0; // 20 ones
  localparam logic [39:0] BAD_KEY  = 40'h00001FFFFF; // 21 ones

  logic clk = 0, rst_n = 0, start_i = 0, check_tick_i = 0, repeater_i = 0;
  logic [31:0] rnd_i = 32'h1234_0000;
  logic rsp_valid_i = 0, rsp_ok_i = 0;
  logic [39:0] rsp_data_i = '0;
  logic an_ready_i, ri_match_i, enc_active_i, list_ready_i;
  logic cmd_valid_o, done_o, fail_o;
  logic [3:0] cmd_code_o, fail_code_o;
  logic [31:0] cmd_data_o;
  logic [1:0] prot_state_o;
  logic [4:0] state_o;

  int n_chk = 0, n_err = 0, cyc = 0;
  int cnt [16];
  int send_an_cyc = 0, ri_first_gap = -1, seed_bad = 0;
  int key_bad_n, rx_bad_n, ri_bad_n, hash_bad_n;
  logic an_ok, enc_ok, enc_kill, list_ok, link_ok, captured;
  logic [39:0] list_word;

  always #10 clk = ~clk; // 50 MHz

  link_auth_seq #(.STAT_TMO(STAT), .R0_WAIT(R0W), .ENC_TMO(ENCT), .LIST_TMO(LISTT))
  u_link_auth_seq (.*);

  assign an_ready_i   = an_ok && captured;
  assign ri_match_i   = (cnt[10] > ri_bad_n);
  assign enc_active_i = enc_ok && ri_match_i && !enc_kill;
  assign list_ready_i = list_ok;

  // Agent model: answers each command at the next negedge.
  always @(negedge clk) begin
    cyc++;
    rsp_valid_i = 0;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) cnt[i] = 0;
      captured = 0; ri_first_gap = -1; seed_bad = 0;
    end else if (cmd_valid_o) begin
      cnt[cmd_code_o]++;
      rsp_ok_i = 1; rsp_data_i = '0;
      case (cmd_code_o)
        4'd1:  rsp_data_i = (cnt[1] > key_bad_n) ? 40'h3 : 40'h1;
        4'd4:  if (cmd_data_o != rnd_i) seed_bad++;
        4'd5:  captured = 1;
        4'd6:  send_an_cyc = cyc;
        4'd7:  rsp_data_i = (cnt[7] > rx_bad_n) ? GOOD_KEY : BAD_KEY;
        4'd10: if (ri_first_gap < 0) ri_first_gap = cyc - send_an_cyc;
        4'd11: rsp_data_i = list_word;
        4'd12: rsp_ok_i = (cnt[12] > hash_bad_n);
        4'd13: captured = 0;
        4'd15: rsp_ok_i = link_ok;
        default: ;
      endcase
      rsp_valid_i = 1;
    end
    rnd_i = rnd_i * 32'd1103515245 + 32'd12345;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup();
    @(negedge clk);
    rst_n = 0; key_bad_n = 0; rx_bad_n = 0; ri_bad_n = 0; hash_bad_n = 0;
    an_ok = 1; enc_ok = 1; enc_kill = 0; list_ok = 1; link_ok = 1;
    repeater_i = 0; list_word = 40'h3; start_i = 0; check_tick_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_end();
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (done_o || fail_o) break;
    end
  endtask

  task automatic run();
    start_i = 1; @(negedge clk); start_i = 0;
    wait_end();
  endtask

  task automatic expect_fail(input string req, input int code);
    chk(fail_o && !done_o, req, fail_o, 1);
    chk(fail_code_o == code[3:0], req, fail_code_o, code);
  endtask

  task automatic t_reset();
    setup();
    chk(state_o == 0, "R12", state_o, 0);
    chk(prot_state_o == 0, "R12", prot_state_o, 0);
    chk(!cmd_valid_o && !done_o && !fail_o, "R12", cmd_valid_o, 0);
  endtask

  task automatic t_happy();
    setup(); run();
    chk(done_o && fail_code_o == 0, "R10", fail_code_o, 0);
    chk(prot_state_o == 2, "R10", prot_state_o, 2);
    chk(cnt[3] == 1 && cnt[4] == 2 && cnt[5] == 1, "R2", cnt[4], 2);
    chk(seed_bad == 0, "R2", seed_bad, 0);
    chk(ri_first_gap >= R0W, "R4", ri_first_gap, R0W);
    chk(cnt[13] == 0 && cnt[14] == 0, "R9", cnt[13], 0);
    @(negedge clk);
    chk(!done_o, "R10", done_o, 0);
  endtask

  task automatic t_keys();
    setup(); key_bad_n = 4; run();
    chk(done_o, "R1", done_o, 1);
    chk(cnt[1] == 5 && cnt[2] == 4, "R1", cnt[2], 4);
    setup(); key_bad_n = 5; run();
    expect_fail("R1", 1);
    chk(cnt[1] == 5 && cnt[2] == 4 && cnt[4] == 0, "R1", cnt[1], 5);
    chk(prot_state_o == 0, "R1", prot_state_o, 0);
  endtask

  task automatic t_an();
    setup(); an_ok = 0; run();
    expect_fail("R2", 2);
    chk(cnt[6] == 0, "R2", cnt[6], 0);
  endtask

  task automatic t_rxkey();
    setup(); rx_bad_n = 1; run();
    chk(done_o && cnt[7] == 2, "R3", cnt[7], 2);
    setup(); rx_bad_n = 100; run();
    expect_fail("R3", 3);
    chk(cnt[7] == 6, "R3", cnt[7], 6);
    chk(cnt[13] == 3 && cnt[14] == 3 && cnt[3] == 1, "R9", cnt[14], 3);
    chk(prot_state_o == 0, "R9", prot_state_o, 0);
  endtask

  task automatic t_ri();
    setup(); ri_bad_n = 2; run();
    chk(done_o && cnt[10] == 3, "R5", cnt[10], 3);
    setup(); ri_bad_n = 100; run();
    expect_fail("R5", 4);
    chk(cnt[10] == 9 && cnt[6] == 3, "R5", cnt[10], 9);
  endtask

  task automatic t_enc();
    setup(); enc_ok = 0; run();
    expect_fail("R6", 5);
    chk(cnt[13] == 3, "R6", cnt[13], 3);
  endtask

  task automatic t_repeater();
    setup(); repeater_i = 1; hash_bad_n = 2; run();
    chk(done_o && cnt[12] == 3, "R8", cnt[12], 3);
    setup(); repeater_i = 1; hash_bad_n = 100; run();
    expect_fail("R8", 9);
    chk(cnt[12] == 9, "R8", cnt[12], 9);
    setup(); repeater_i = 1; list_word = 40'h83; run();
    expect_fail("R7", 7);
    setup(); repeater_i = 1; list_word = 40'h803; run();
    expect_fail("R7", 7);
    setup(); repeater_i = 1; list_word = 40'h0; run();
    expect_fail("R7", 8);
    chk(cnt[12] == 0, "R7", cnt[12], 0);
    setup(); repeater_i = 1; list_ok = 0; run();
    expect_fail("R7", 6);
    chk(cnt[11] == 0, "R7", cnt[11], 0);
  endtask

  task automatic t_periodic();
    setup(); run();
    enc_kill = 1; check_tick_i = 1; @(negedge clk); check_tick_i = 0;
    chk(fail_o && fail_code_o == 10, "R11", fail_code_o, 10);
    chk(prot_state_o == 1 && state_o == 0, "R11", prot_state_o, 1);
    setup(); run();
    link_ok = 0; check_tick_i = 1; @(negedge clk); check_tick_i = 0;
    for (int i = 0; i < 50 && cnt[13] == 0; i++) @(negedge clk);
    chk(prot_state_o == 1 && cnt[15] == 1, "R11", prot_state_o, 1);
    wait_end();
    chk(done_o && prot_state_o == 2, "R11", prot_state_o, 2);
    chk(cnt[1] == 2 && cnt[13] == 1 && cnt[14] == 1, "R11", cnt[1], 2);
  endtask

  initial begin
    t_reset();
    t_happy();
    t_keys();
    t_an();
    t_rxkey();
    t_ri();
    t_enc();
    t_repeater();
    t_periodic();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule